// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a tiny processor that has exactly one instruction and no opcode. Every cycle it fetches one wide word from its instruction store and reads two source registers. It writes their difference into a destination register. When the difference is negative, it loads the program counter with a target address carried in the word. Otherwise the program counter steps to the next word, 4 bytes on. Each field sits at a fixed position in the word, so decoding is only wiring.

A load mode, entered after reset, lets the surrounding environment fill the instruction store and place starting values in registers. Execution starts when load mode is released. It stops for good when a taken branch names the address of the instruction that took it. The block then raises a halt flag and holds the program counter. A debug read port shows any register at any time.

Top module: `sbn_core`

## Requirements
- R1: Synchronous active-low reset sets the program counter to 0, clears the halt flag and sets every register to 0.
- R2: While load_mode is high, nothing executes and the program counter holds. A pulse on init_we writes init_data into the instruction store word init_addr when init_rom is 1. When init_rom is 0, it writes init_data[31:0] into register init_addr instead.
- R3: Each executed instruction writes A - B, modulo 2^32, into the destination register at the closing clock edge. Later instructions see the new value.
- R4: The result counts as negative when bit 31 of the 32-bit difference is 1, including wrapped cases. A negative result loads the program counter with the target field.
- R5: A zero or positive result advances the program counter by 4.
- R6: A taken branch whose target equals the current program counter sets halt_o. From then until reset, the program counter holds and no register is written.
- R7: The instruction that causes the halt still writes its result.
- R8: Both operands are read before the write. When the destination equals a source, the old value is used.
- R9: The word layout is target [47:32], destination [31:24], source A [23:16], source B [15:8], and ignored bits [7:0]. Register fields use their low log2(NREGS) bits (4 bits by default). The instruction store is indexed by pc[ROM_AW+1:2].
- R10: dbg_data shows, combinationally, the register selected by the low bits of dbg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_mode | input | 1 | Hold execution and enable initial loading |
| init_we | input | 1 | Initial-load write strobe |
| init_rom | input | 1 | 1 selects the instruction store, 0 selects the register file |
| init_addr | input | 8 | Word or register index for the load |
| init_data | input | 48 | Load data (registers take bits 31:0) |
| pc_o | output | 16 | Current program counter (byte address) |
| halt_o | output | 1 | Halt flag |
| dbg_addr | input | 8 | Debug register select |
| dbg_data | output | 32 | Debug register value |

## Verification
Writeback and the branch decision happen on the same clock edge. The sharpest case is the halting instruction, which must commit its result and freeze the counter together. The tests provoke this with a self-targeted instruction that uses its own destination as a source. A second execution would therefore change the stored value. Each test then checks the written value, the held counter and the unchanged register over later cycles. The wrapped difference 0x7FFFFFFF - 0xFFFFFFFF is used so that the negative decision comes from bit 31 and not from the true sign.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  localparam int DATA_W = 32;
  localparam int PC_W   = 16;
  localparam int INSN_W = 48;

  typedef struct packed {
    logic [PC_W-1:0] target;
    logic [7:0]      dst;
    logic [7:0]      src_a;
    logic [7:0]      src_b;
    logic [7:0]      spare;
  } insn_t;

  function automatic logic [DATA_W-1:0] sbn_diff(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic sbn_is_neg(input logic [DATA_W-1:0] d);
    return d[DATA_W-1];
  endfunction

  function automatic logic [PC_W-1:0] sbn_seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction
endpackage

// File: rtl/sbn_fetch.sv
module sbn_fetch
  import sbn_pkg::*;
#(
  parameter int ROM_DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rom_we,
  input  logic [7:0]      rom_waddr,
  input  insn_t           rom_wdata,
  input  logic            pc_load,
  input  logic [PC_W-1:0] pc_next,
  output logic [PC_W-1:0] pc,
  output insn_t           insn
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);

  insn_t           rom [ROM_DEPTH];
  logic [PC_W-1:0] pc_q;
  logic [ROM_AW-1:0] rd_idx;
  logic              unused_bits;

  assign rd_idx      = pc_q[ROM_AW+1:2];
  assign unused_bits = ^{pc_q[1:0], pc_q[PC_W-1:ROM_AW+2], rom_waddr[7:ROM_AW]};

  always_ff @(posedge clk) begin
    if (rom_we) rom[rom_waddr[ROM_AW-1:0]] <= rom_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (pc_load) pc_q <= pc_next;
  end

  assign pc   = pc_q;
  assign insn = rom[rd_idx];
endmodule

// File: rtl/sbn_regfile.sv
module sbn_regfile
  import sbn_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  input  logic [$clog2(NREGS)-1:0] ra_dbg,
  output logic [DATA_W-1:0]        rd_a,
  output logic [DATA_W-1:0]        rd_b,
  output logic [DATA_W-1:0]        rd_dbg,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [DATA_W-1:0]        wd
);
  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a   = regs[ra_a];
  assign rd_b   = regs[ra_b];
  assign rd_dbg = regs[ra_dbg];
endmodule

// File: rtl/sbn_exec.sv
module sbn_exec
  import sbn_pkg::*;
(
  input  insn_t             insn,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              taken,
  output logic              halt_hit,
  output logic [PC_W-1:0]   pc_next
);
  always_comb begin
    result   = sbn_diff(opa, opb);
    taken    = sbn_is_neg(result);
    pc_next  = taken ? insn.target : sbn_seq_pc(pc);
    halt_hit = taken && (insn.target == pc);
  end
endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int NREGS     = 16,
  parameter int ROM_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_mode,
  input  logic        init_we,
  input  logic        init_rom,
  input  logic [7:0]  init_addr,
  input  logic [47:0] init_data,
  output logic [15:0] pc_o,
  output logic        halt_o,
  input  logic [7:0]  dbg_addr,
  output logic [31:0] dbg_data
);
  localparam int REG_AW = $clog2(NREGS);

  insn_t             insn;
  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pc_next;
  logic [PC_W-1:0]   br_target;
  logic [DATA_W-1:0] opa, opb, result;
  logic              taken, halt_hit, halt_q, step;
  logic              rf_we, rom_we;
  logic [REG_AW-1:0] rf_wa;
  logic [DATA_W-1:0] rf_wd;
  logic              unused_bits;

  assign step      = !load_mode && !halt_q;
  assign rom_we    = load_mode && init_we && init_rom;
  assign rf_we     = step || (load_mode && init_we && !init_rom);
  assign rf_wa     = step ? insn.dst[REG_AW-1:0] : init_addr[REG_AW-1:0];
  assign rf_wd     = step ? result : init_data[DATA_W-1:0];
  assign br_target = insn.target;
  assign unused_bits = ^{insn.spare, insn.dst[7:REG_AW], insn.src_a[7:REG_AW],
                         insn.src_b[7:REG_AW], dbg_addr[7:REG_AW],
                         init_addr[7:REG_AW], init_data[47:DATA_W]};

  sbn_fetch #(.ROM_DEPTH(ROM_DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .rom_we(rom_we), .rom_waddr(init_addr),
    .rom_wdata(insn_t'(init_data)), .pc_load(step), .pc_next(pc_next),
    .pc(pc), .insn(insn)
  );

  sbn_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(insn.src_a[REG_AW-1:0]), .ra_b(insn.src_b[REG_AW-1:0]),
    .ra_dbg(dbg_addr[REG_AW-1:0]),
    .rd_a(opa), .rd_b(opb), .rd_dbg(dbg_data),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  sbn_exec u_exec (
    .insn(insn), .pc(pc), .opa(opa), .opb(opb),
    .result(result), .taken(taken), .halt_hit(halt_hit), .pc_next(pc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                halt_q <= 1'b0;
    else if (step && halt_hit) halt_q <= 1'b1;
  end

  assign pc_o   = pc;
  assign halt_o = halt_q;
endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_mode,
  input logic        step,
  input logic        taken,
  input logic [15:0] br_target,
  input logic        halt_o,
  input logic [15:0] pc_o,
  input logic        rf_we
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pc_o == 16'd0 && !halt_o));

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> $stable(pc_o));

  // R4
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken) |=> (pc_o == $past(br_target)));

  // R5
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !taken) |=> (pc_o == $past(pc_o) + 16'd4));

  // R6
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken && br_target == pc_o) |=> halt_o);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> (halt_o && $stable(pc_o)));

  // R6
  halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !load_mode) |-> !rf_we);
endmodule

bind sbn_core sbn_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .step(step),
  .taken(taken), .br_target(br_target), .halt_o(halt_o), .pc_o(pc_o),
  .rf_we(rf_we)
);

// File: tb/sbn_core_bench.sv
module sbn_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_mode = 1'b0;
  logic        init_we = 1'b0;
  logic        init_rom = 1'b0;
  logic [7:0]  init_addr = '0;
  logic [47:0] init_data = '0;
  logic [15:0] pc_o;
  logic        halt_o;
  logic [7:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbn_core u_sbn_core (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .init_we(init_we),
    .init_rom(init_rom), .init_addr(init_addr), .init_data(init_data),
    .pc_o(pc_o), .halt_o(halt_o), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [47:0] mk(input logic [15:0] tgt, input logic [7:0] d,
                                     input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] sp = 8'h00);
    return {tgt, d, a, b, sp};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    dbg_addr = 8'(idx);
    #1;
    v = dbg_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load_mode = 1'b0; init_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input bit rom, input int idx, input logic [47:0] data);
    @(negedge clk);
    init_rom = rom; init_addr = 8'(idx); init_data = data; init_we = 1'b1;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 pc", 32'(pc_o), 32'h0);
    chk("R1 halt", 32'(halt_o), 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R1/R10 reg clear", v, 32'h0);
    end
  endtask

  // program A: sequential, zero, branch over skipped words, halt
  task automatic test_prog_a();
    logic [31:0] v;
    do_reset();
    load_mode = 1'b1;
    load(1'b0, 1, 48'd10);
    load(1'b0, 2, 48'd3);
    rd(1, v); chk("R2/R10 reg load r1", v, 32'd10);
    rd(2, v); chk("R2/R10 reg load r2", v, 32'd3);
    load(1'b1, 0, mk(16'h0040, 8'd3, 8'd1, 8'd2));
    load(1'b1, 1, mk(16'h0044, 8'd4, 8'd2, 8'd2, 8'hFF));
    load(1'b1, 2, mk(16'h0014, 8'd5, 8'd2, 8'd1));
    load(1'b1, 3, mk(16'h0000, 8'd6, 8'd1, 8'd2));
    load(1'b1, 4, mk(16'h0000, 8'd6, 8'd1, 8'd2));
    load(1'b1, 5, mk(16'h0000, 8'd7, 8'd1, 8'd2));
    load(1'b1, 6, mk(16'h0018, 8'd8, 8'd2, 8'd1));
    repeat (3) @(negedge clk);
    chk("R2 pc held in load mode", 32'(pc_o), 32'h0);
    rd(3, v); chk("R2 no execution in load mode", v, 32'h0);
    load_mode = 1'b0;
    @(negedge clk); chk("R5 pc+4 nonneg", 32'(pc_o), 32'h4);
    rd(3, v); chk("R3 r3=10-3", v, 32'd7);
    @(negedge clk); chk("R5 pc+4 on zero", 32'(pc_o), 32'h8);
    rd(4, v); chk("R9 spare bits ignored r4", v, 32'd0);
    @(negedge clk); chk("R4 taken to target", 32'(pc_o), 32'h14);
    rd(5, v); chk("R3 r5=3-10", v, 32'hFFFF_FFF9);
    chk("R4 no halt on far branch", 32'(halt_o), 32'h0);
    @(negedge clk); chk("R5 pc after w5", 32'(pc_o), 32'h18);
    rd(6, v); chk("R4 skipped words not run", v, 32'h0);
    rd(7, v); chk("R3 r7", v, 32'd7);
    @(negedge clk);
    chk("R6 halt set", 32'(halt_o), 32'h1);
    chk("R6 pc at self target", 32'(pc_o), 32'h18);
    rd(8, v); chk("R7 halting write", v, 32'hFFFF_FFF9);
    repeat (5) @(negedge clk);
    chk("R6 pc frozen", 32'(pc_o), 32'h18);
    chk("R6 halt sticky", 32'(halt_o), 32'h1);
  endtask

  // program B: read-before-write, wrapped negative, self-modifying halt
  task automatic test_prog_b();
    logic [31:0] v;
    do_reset();
    rd(3, v); chk("R1 regs cleared again", v, 32'h0);
    load_mode = 1'b1;
    load(1'b0, 1, 48'd5);
    load(1'b0, 2, 48'd2);
    load(1'b0, 12, 48'h7FFF_FFFF);
    load(1'b0, 13, 48'hFFFF_FFFF);
    load(1'b1, 0, mk(16'h0030, 8'd1, 8'd1, 8'd2));
    load(1'b1, 1, mk(16'h0030, 8'd9, 8'd1, 8'd2));
    load(1'b1, 2, mk(16'h0008, 8'h1C, 8'h0C, 8'h2D));
    load_mode = 1'b0;
    @(negedge clk);
    rd(1, v); chk("R8 dest==src uses old value", v, 32'd3);
    chk("R5 pc", 32'(pc_o), 32'h4);
    @(negedge clk);
    rd(9, v); chk("R3 new value visible", v, 32'd1);
    @(negedge clk);
    chk("R4 wrapped bit31 taken/halt", 32'(halt_o), 32'h1);
    chk("R6 pc held at 8", 32'(pc_o), 32'h8);
    rd(12, v); chk("R7/R9 halting write low index bits", v, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd(12, v); chk("R6 no write while halted", v, 32'h8000_0000);
    chk("R6 pc still 8", 32'(pc_o), 32'h8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_prog_a();
    test_prog_b();
    finish_run();
  end
endmodule